// File: doc/BRIEF.md
# DMA Channel Enable and Interrupt Control

This block keeps the enable and interrupt control state of a single DMA channel. Software reaches four control bits through a simple read/write strobe interface. The bits are a channel enable, a master enable, an end-of-transfer interrupt enable and a break interrupt enable. The transfer engine supplies an activation request, a per-transfer done pulse and a final-count done pulse. It receives a one-cycle start strobe for each accepted request.

The channel enable can only be turned on through a guarded sequence. Software must first read the register while the enable is clear, and then write 1. A write of 1 without that preceding read leaves the enable off. When the enable drops while the end interrupt enable is set, an end-of-transfer interrupt is raised. When the master enable drops while the break interrupt enable is set, a break interrupt is raised. Each interrupt stays pending until software cancels it. While the channel is disabled, an activation request from an internal source is forwarded to the CPU as a plain interrupt request.

Top module: `dmaen_chan`

## Requirements
- R1: A start strobe is issued only when the channel enable (register bit 0) and the master enable (register bit 1) are both 1 and an activation request is present. The strobe appears in the cycle after the request is sampled and lasts exactly one cycle.
- R2: While the channel enable is 0, activation requests produce no start strobe. With `REQ_INTERNAL`=1, `cpuIrq` follows `actReq` combinationally while the channel enable is 0.
- R3: The channel enable is cleared by a `cntDone` pulse and by a bus write with bit 0 equal to 0.
- R4: A bus write with bit 0 equal to 1 sets the channel enable only if the most recent bus access before it was a read that returned bit 0 as 0. Any write disarms this condition, and a write of 1 without it leaves the enable unchanged.
- R5: When the channel enable falls while the end interrupt enable (bit 2) is 1, `endIrq` is asserted.
- R6: When the master enable falls while the break interrupt enable (bit 3) is 1, `brkIrq` is asserted.
- R7: A pending `brkIrq` is cancelled by clearing bit 3 or by setting the master enable back to 1.
- R8: A pending `endIrq` is cancelled by clearing bit 2 or by setting the channel enable again.
- R9: After reset, all four control bits and all outputs are 0.
- R10: Requests that arrive while a transfer is in progress, between a start strobe and `xferDone` or `cntDone`, are held as one pending request. That request launches in the cycle after the transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdEn | input | 1 | Bus read strobe for the control register |
| wrEn | input | 1 | Bus write strobe for the control register |
| wrData | input | 4 | Write data: bit0 channel enable, bit1 master enable, bit2 end irq enable, bit3 break irq enable |
| rdData | output | 4 | Current control bits, same layout as wrData |
| actReq | input | 1 | Activation request from the peripheral |
| xferDone | input | 1 | Pulse when the current transfer completes |
| cntDone | input | 1 | Pulse when the programmed transfer count is reached |
| startStb | output | 1 | One-cycle transfer start strobe |
| endIrq | output | 1 | Transfer-end interrupt, level |
| brkIrq | output | 1 | Transfer-break interrupt, level |
| cpuIrq | output | 1 | Activation request forwarded to the CPU while disabled |

## Verification
The bench builds the block with `REQ_INTERNAL`=1, so the forwarding of requests to the CPU while the channel is disabled is visible at `cpuIrq`. The width is left at its default of four control bits, which puts every control bit, and both interrupt set and cancel paths, under direct bus control. With this setting the bench can reach the arming sequence, the single pending request during a busy transfer, and both cancel routes for each interrupt.

// File: rtl/dmaen_pkg.sv
package dmaen_pkg;
  localparam int CTRL_W  = 4;
  localparam int BIT_EN  = 0;
  localparam int BIT_ME  = 1;
  localparam int BIT_EIE = 2;
  localparam int BIT_BIE = 3;

  typedef struct packed {
    logic              wrStb;
    logic              enSet;
    logic              enClr;
    logic [CTRL_W-1:0] wrVal;
  } busCmd_t;
endpackage

// File: rtl/dmaen_ctrl.sv
module dmaen_ctrl
  import dmaen_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  input  logic [CTRL_W-1:0] ctrlBits,
  output busCmd_t           cmd
);
  logic armed;

  // Arming flag: a read that returns the enable as 0 arms, any write disarms.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        armed <= 1'b0;
    else if (wrEn)                    armed <= 1'b0;
    else if (rdEn && !ctrlBits[BIT_EN]) armed <= 1'b1;
  end

  always_comb begin
    cmd.wrStb = wrEn;
    cmd.wrVal = wrData;
    cmd.enSet = wrEn &&  wrData[BIT_EN] && armed;
    cmd.enClr = wrEn && !wrData[BIT_EN];
  end

  // R4: an unarmed write of 1 never sets the enable
  assert_unarmed_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[BIT_EN] && !armed && !ctrlBits[BIT_EN]) |=> !ctrlBits[BIT_EN]);
endmodule

// File: rtl/dmaen_regs.sv
module dmaen_regs
  import dmaen_pkg::*;
#(
  parameter bit REQ_INTERNAL = 1'b1
)(
  input  logic              clk,
  input  logic              rstN,
  input  busCmd_t           cmd,
  input  logic              cntDone,
  input  logic              actReq,
  output logic [CTRL_W-1:0] ctrlBits,
  output logic              endIrq,
  output logic              brkIrq,
  output logic              cpuIrq
);
  logic [CTRL_W-1:0] bitsNext;
  logic              endPend, brkPend;

  // Channel enable: count completion and forced suspend win over a set.
  always_comb begin
    bitsNext = ctrlBits;
    if (cntDone || cmd.enClr) bitsNext[BIT_EN] = 1'b0;
    else if (cmd.enSet)       bitsNext[BIT_EN] = 1'b1;
  end

  // Plain control bits follow any write.
  for (genvar i = 0; i < CTRL_W; i++) begin : g_bit
    if (i == BIT_EN) begin : g_en
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) ctrlBits[i] <= 1'b0;
        else       ctrlBits[i] <= bitsNext[i];
    end else begin : g_plain
      always_ff @(posedge clk or negedge rstN)
        if (!rstN)          ctrlBits[i] <= 1'b0;
        else if (cmd.wrStb) ctrlBits[i] <= cmd.wrVal[i];
    end
  end

  logic meNext, eieNext, bieNext;
  assign meNext  = cmd.wrStb ? cmd.wrVal[BIT_ME]  : ctrlBits[BIT_ME];
  assign eieNext = cmd.wrStb ? cmd.wrVal[BIT_EIE] : ctrlBits[BIT_EIE];
  assign bieNext = cmd.wrStb ? cmd.wrVal[BIT_BIE] : ctrlBits[BIT_BIE];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      endPend <= 1'b0;
      brkPend <= 1'b0;
    end else begin
      endPend <= eieNext && !bitsNext[BIT_EN] &&
                 (endPend || ctrlBits[BIT_EN]);
      brkPend <= bieNext && !meNext &&
                 (brkPend || ctrlBits[BIT_ME]);
    end
  end

  assign endIrq = endPend;
  assign brkIrq = brkPend;
  assign cpuIrq = REQ_INTERNAL && actReq && !ctrlBits[BIT_EN];

  assert_cnt_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    cntDone |=> !ctrlBits[BIT_EN]);
  assert_set_source_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlBits[BIT_EN]) |-> $past(cmd.enSet));
  assert_end_raise_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ctrlBits[BIT_EN]) && ctrlBits[BIT_EIE]) |-> endIrq);
  assert_brk_raise_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ctrlBits[BIT_ME]) && ctrlBits[BIT_BIE]) |-> brkIrq);
  assert_brk_cancel_R7: assert property (@(posedge clk) disable iff (!rstN)
    brkIrq |-> (ctrlBits[BIT_BIE] && !ctrlBits[BIT_ME]));
  assert_end_cancel_R8: assert property (@(posedge clk) disable iff (!rstN)
    endIrq |-> (ctrlBits[BIT_EIE] && !ctrlBits[BIT_EN]));
endmodule

// File: rtl/dmaen_launch.sv
module dmaen_launch (
  input  logic clk,
  input  logic rstN,
  input  logic gate,
  input  logic actReq,
  input  logic xferDone,
  input  logic cntDone,
  output logic startStb
);
  logic busy, pendReq, reqSeen, launch;

  assign reqSeen = gate && actReq;
  assign launch  = !busy && (reqSeen || (pendReq && gate));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      pendReq  <= 1'b0;
      startStb <= 1'b0;
    end else begin
      startStb <= launch;
      if (launch) begin
        busy    <= 1'b1;
        pendReq <= 1'b0;
      end else begin
        if (xferDone || cntDone) busy <= 1'b0;
        if (!gate)               pendReq <= 1'b0;
        else if (reqSeen)        pendReq <= 1'b1;
      end
    end
  end

  assert_start_gated_R1: assert property (@(posedge clk) disable iff (!rstN)
    startStb |-> $past(gate));
  assert_single_cycle_R1: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> !startStb);
  assert_no_start_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !xferDone && !cntDone) |=> !startStb);
endmodule

// File: rtl/dmaen_chan.sv
module dmaen_chan
  import dmaen_pkg::*;
#(
  parameter bit REQ_INTERNAL = 1'b1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  output logic [CTRL_W-1:0] rdData,
  input  logic              actReq,
  input  logic              xferDone,
  input  logic              cntDone,
  output logic              startStb,
  output logic              endIrq,
  output logic              brkIrq,
  output logic              cpuIrq
);
  busCmd_t           cmd;
  logic [CTRL_W-1:0] ctrlBits;

  dmaen_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .ctrlBits(ctrlBits), .cmd(cmd)
  );

  dmaen_regs #(.REQ_INTERNAL(REQ_INTERNAL)) u_regs (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cntDone(cntDone), .actReq(actReq),
    .ctrlBits(ctrlBits), .endIrq(endIrq), .brkIrq(brkIrq), .cpuIrq(cpuIrq)
  );

  dmaen_launch u_launch (
    .clk(clk), .rstN(rstN),
    .gate(ctrlBits[BIT_EN] && ctrlBits[BIT_ME]),
    .actReq(actReq), .xferDone(xferDone), .cntDone(cntDone),
    .startStb(startStb)
  );

  assign rdData = ctrlBits;
endmodule

// File: tb/sim_dmaen_chan.sv
module sim_dmaen_chan;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rdEn = 1'b0, wrEn = 1'b0;
  logic [3:0] wrData = 4'h0;
  logic [3:0] rdData;
  logic       actReq = 1'b0, xferDone = 1'b0, cntDone = 1'b0;
  logic       startStb, endIrq, brkIrq, cpuIrq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  string      tagQ[$];
  logic [7:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dmaen_chan #(.REQ_INTERNAL(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .actReq(actReq), .xferDone(xferDone), .cntDone(cntDone),
    .startStb(startStb), .endIrq(endIrq), .brkIrq(brkIrq), .cpuIrq(cpuIrq)
  );

  // Observation vector: {cpuIrq, brkIrq, endIrq, startStb, rdData[3:0]}
  wire [7:0] obs = {cpuIrq, brkIrq, endIrq, startStb, rdData};

  task automatic expect_obs(string tag, logic [7:0] exp);
    tagQ.push_back(tag);
    expQ.push_back(exp);
    #2;
  endtask

  // Monitor: pops expected items and compares them with the design outputs.
  initial begin
    forever begin
      wait (expQ.size() != 0);
      #1;
      checks++;
      if (obs !== expQ[0]) begin
        failures++;
        $display("FAIL %s got=%b exp=%b", tagQ[0], obs, expQ[0]);
      end
      void'(tagQ.pop_front());
      void'(expQ.pop_front());
    end
  end

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic busWr(logic [3:0] v);
    wrEn = 1'b1; wrData = v;
    cyc();
    wrEn = 1'b0;
  endtask

  task automatic busRd();
    rdEn = 1'b1;
    cyc();
    rdEn = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !finished) begin
      failures++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    rstN = 1'b1;
    cyc();
    expect_obs("R9 reset state", 8'b0000_0000);

    // R4: write 1 with no arming read is ignored for the enable
    busWr(4'b0011);
    expect_obs("R4 unarmed set ignored", 8'b0000_0010);
    busRd();
    busWr(4'b0011);
    expect_obs("R4 armed set", 8'b0000_0011);

    // R1: accepted request -> one-cycle strobe
    actReq = 1'b1; cyc(); actReq = 1'b0;
    expect_obs("R1 start strobe", 8'b0001_0011);
    cyc();
    expect_obs("R1 strobe one cycle", 8'b0000_0011);

    // R10: requests while busy collapse to one pending launch
    actReq = 1'b1; cyc(); cyc(); actReq = 1'b0;
    expect_obs("R10 no start while busy", 8'b0000_0011);
    xferDone = 1'b1; cyc(); xferDone = 1'b0;
    expect_obs("R10 done edge", 8'b0000_0011);
    cyc();
    expect_obs("R10 pending launch", 8'b0001_0011);
    cyc();
    expect_obs("R10 pending strobe ends", 8'b0000_0011);
    xferDone = 1'b1; cyc(); xferDone = 1'b0; cyc();
    expect_obs("R10 only one pending", 8'b0000_0011);

    // R3/R5: count completion clears enable, raises end irq
    busWr(4'b0111);
    expect_obs("R4 write 1 keeps enable", 8'b0000_0111);
    cntDone = 1'b1; cyc(); cntDone = 1'b0;
    expect_obs("R3 R5 count done end irq", 8'b0010_0110);
    actReq = 1'b1;
    expect_obs("R2 forwarded to cpu", 8'b1010_0110);
    cyc(); actReq = 1'b0;
    expect_obs("R2 no start when disabled", 8'b0010_0110);

    // R8: cancel end irq by re-enabling, then by clearing its enable
    busRd();
    busWr(4'b0111);
    expect_obs("R8 cancel by enable", 8'b0000_0111);
    busWr(4'b0110);
    expect_obs("R3 R5 forced suspend", 8'b0010_0110);
    busWr(4'b0010);
    expect_obs("R8 cancel by irq enable clear", 8'b0000_0010);

    // R6/R7: break irq raise and both cancel routes
    busWr(4'b1010);
    expect_obs("R6 setup", 8'b0000_1010);
    busWr(4'b1000);
    expect_obs("R6 break raise", 8'b0100_1000);
    busWr(4'b1010);
    expect_obs("R7 cancel by master set", 8'b0000_1010);
    busWr(4'b1000);
    expect_obs("R6 break raise again", 8'b0100_1000);
    busWr(4'b0000);
    expect_obs("R7 cancel by irq enable clear", 8'b0000_0000);

    // R4: any write disarms
    busRd();
    busWr(4'b0010);
    busWr(4'b0011);
    expect_obs("R4 write disarms", 8'b0000_0010);
    actReq = 1'b1;
    expect_obs("R2 cpu pass-through", 8'b1000_0010);
    cyc(); actReq = 1'b0;
    expect_obs("R2 no strobe", 8'b0000_0010);

    // R1: enable without master enable never starts
    busRd();
    busWr(4'b0001);
    expect_obs("R1 enable only", 8'b0000_0001);
    actReq = 1'b1; cyc(); actReq = 1'b0;
    expect_obs("R1 no start without master", 8'b0000_0001);
    busWr(4'b0011);
    cyc();
    expect_obs("R1 no stale launch", 8'b0000_0011);

    wait (expQ.size() == 0);
    #5;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule